// File: doc/BRIEF.md
# Prefix and Register-Select Decoder

This block sits at the front of a small coprocessor's decode stage and interprets the one-byte prefixes of its instruction stream. The prefixes are sticky. An ALT prefix changes the meaning of the next real opcode. A TO prefix picks the destination register, a FROM prefix picks the source register, and a WITH prefix picks one register as both. These selections persist over any number of cycles and over further prefixes until a non-prefix instruction consumes them. After that instruction, everything returns to its defaults: no ALT mode and register 0 for both source and destination.

Each byte arrives with a valid strobe. On the same cycle, the block reports one of two results. Either the byte was absorbed as a prefix, or it issues an instruction. For an issued instruction it gives the effective ALT mode, the source and destination indices, and the opcode split into its operation nibble and register nibble. WITH also arms a mode in which the next TO-coded or FROM-coded byte is not taken as a prefix. Instead it becomes a register-to-register move, plain or flag-setting. The block also presents its held state as a 16-bit flag word whose bit positions match the processor's status register. It does not execute operations and does not fetch immediate operands.

Top module: `prefix_sel_decoder`

## Requirements
- R1: After reset, no ALT flag and no WITH mode are held, and the held source and destination indices are both 0.
- R2: A valid byte 0x3D sets ALT1, 0x3E sets ALT2 and 0x3F sets both. These are absorbed as prefixes (o_prefix=1, o_exec=0). They OR into flags already held, so 0x3E then 0x3D leaves both set.
- R3: With WITH mode clear, a valid byte 0x1n is absorbed as a prefix and sets the held destination to n. A valid byte 0xBn is absorbed as a prefix and sets the held source to n.
- R4: A valid byte 0x2n is absorbed as a prefix. It sets both the held source and the held destination to n and sets WITH mode.
- R5: With WITH mode set, a valid byte 0x1m issues an instruction with o_move=1, o_src=m, and o_dst equal to the register chosen by the WITH prefix.
- R6: With WITH mode set, a valid byte 0xBm issues an instruction with o_move_flags=1, o_src=m, and o_dst equal to the WITH register.
- R7: Any other valid byte issues an instruction (o_exec=1) with o_alt = {ALT2, ALT1} as held, the held source and destination indices, o_op_nib = byte[7:4] and o_reg_nib = byte[3:0].
- R8: The cycle after any instruction issues (including a move), ALT1, ALT2 and WITH mode are clear and both held indices are 0.
- R9: Prefixes do not clear each other. ALT, TO and FROM may come in any order, and all their effects reach the next instruction.
- R10: On a cycle without op_valid, the held state is unchanged and o_exec and o_prefix are 0.
- R11: status_flags carries ALT1 in bit 8, ALT2 in bit 9 and WITH mode in bit 12. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | op_byte holds a stream byte this cycle |
| op_byte | input | 8 | Instruction stream byte |
| o_exec | output | 1 | Byte issues an instruction |
| o_prefix | output | 1 | Byte absorbed as a prefix |
| o_move | output | 1 | Issued instruction is a plain register move |
| o_move_flags | output | 1 | Issued instruction is a flag-setting register move |
| o_alt | output | 2 | Effective ALT mode {ALT2, ALT1} |
| o_src | output | 4 | Effective source register index |
| o_dst | output | 4 | Effective destination register index |
| o_op_nib | output | 4 | Operation nibble of the byte |
| o_reg_nib | output | 4 | Register nibble of the byte |
| sel_src_q | output | 4 | Held source selection |
| sel_dst_q | output | 4 | Held destination selection |
| status_flags | output | 16 | Held prefix flags at status-register positions |

## Verification
The assertions cover the rules that hold on every cycle:
- state returns to defaults after an issue;
- WITH leaves source equal to destination with the mode bit set;
- ALT bits only accumulate;
- idle cycles leave the state untouched;
- a valid byte is exactly one of prefix or instruction;
- a move issues only under WITH mode.

Only the bench's byte sequences can show that the right register numbers travel to the issued instruction. These sequences cover prefixes in swapped orders, selections kept across idle gaps, re-selection by a second WITH, and a move that targets the WITH register while taking its source from the following byte.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int BYTE_W     = 8;
    localparam int NIB_W      = BYTE_W / 2;
    localparam int NUM_GPR    = 16;
    localparam int IDX_W      = $clog2(NUM_GPR);
    localparam int ALT_W      = 2;
    localparam int FLAG_W     = 16;
    localparam int FLAG_ALT1  = 8;
    localparam int FLAG_ALT2  = 9;
    localparam int FLAG_WITH  = 12;

    localparam logic [NIB_W-1:0] NIB_TO   = 4'h1;
    localparam logic [NIB_W-1:0] NIB_WITH = 4'h2;
    localparam logic [NIB_W-1:0] NIB_ALT  = 4'h3;
    localparam logic [NIB_W-1:0] NIB_FROM = 4'hB;
    localparam logic [NIB_W-1:2] ALT_LOW_TOP = 2'b11;

    typedef enum logic [2:0] {
        K_OTHER,
        K_ALT,
        K_TO,
        K_FROM,
        K_WITH
    } kind_e;

    typedef struct packed {
        logic             alt1;
        logic             alt2;
        logic             with_md;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } sel_state_t;

    localparam sel_state_t SEL_IDLE = '{alt1: 1'b0, alt2: 1'b0, with_md: 1'b0,
                                        src: '0, dst: '0};
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output kind_e             kind_o,
    output logic [ALT_W-1:0]  alt_bits_o,
    output logic [NIB_W-1:0]  op_nib_o,
    output logic [NIB_W-1:0]  reg_nib_o
);
    always_comb begin
        op_nib_o   = byte_i[BYTE_W-1:NIB_W];
        reg_nib_o  = byte_i[NIB_W-1:0];
        alt_bits_o = '0;
        kind_o     = K_OTHER;
        unique case (op_nib_o)
            NIB_TO:   kind_o = K_TO;
            NIB_FROM: kind_o = K_FROM;
            NIB_WITH: kind_o = K_WITH;
            NIB_ALT: begin
                // only the top three codes of this row are prefixes
                if (reg_nib_o[NIB_W-1:2] == ALT_LOW_TOP && reg_nib_o[1:0] != 2'b00) begin
                    kind_o     = K_ALT;
                    alt_bits_o = reg_nib_o[ALT_W-1:0];
                end
            end
            default: kind_o = K_OTHER;
        endcase
    end
endmodule

// File: rtl/pfx_next.sv
module pfx_next
    import pfx_pkg::*;
(
    input  logic              valid_i,
    input  kind_e             kind_i,
    input  logic [ALT_W-1:0]  alt_bits_i,
    input  logic [NIB_W-1:0]  reg_nib_i,
    input  sel_state_t        cur_i,
    output sel_state_t        nxt_o,
    output logic              exec_o,
    output logic              prefix_o,
    output logic              move_o,
    output logic              move_flags_o,
    output logic [ALT_W-1:0]  alt_o,
    output logic [IDX_W-1:0]  src_o,
    output logic [IDX_W-1:0]  dst_o
);
    always_comb begin
        nxt_o        = cur_i;
        exec_o       = 1'b0;
        prefix_o     = 1'b0;
        move_o       = 1'b0;
        move_flags_o = 1'b0;
        alt_o        = {cur_i.alt2, cur_i.alt1};
        src_o        = cur_i.src;
        dst_o        = cur_i.dst;
        if (valid_i) begin
            unique case (kind_i)
                K_ALT: begin
                    prefix_o   = 1'b1;
                    nxt_o.alt1 = cur_i.alt1 | alt_bits_i[0];
                    nxt_o.alt2 = cur_i.alt2 | alt_bits_i[1];
                end
                K_TO: begin
                    if (cur_i.with_md) begin
                        exec_o = 1'b1;
                        move_o = 1'b1;
                        src_o  = reg_nib_i[IDX_W-1:0];
                        nxt_o  = SEL_IDLE;
                    end else begin
                        prefix_o  = 1'b1;
                        nxt_o.dst = reg_nib_i[IDX_W-1:0];
                    end
                end
                K_FROM: begin
                    if (cur_i.with_md) begin
                        exec_o       = 1'b1;
                        move_flags_o = 1'b1;
                        src_o        = reg_nib_i[IDX_W-1:0];
                        nxt_o        = SEL_IDLE;
                    end else begin
                        prefix_o  = 1'b1;
                        nxt_o.src = reg_nib_i[IDX_W-1:0];
                    end
                end
                K_WITH: begin
                    prefix_o      = 1'b1;
                    nxt_o.src     = reg_nib_i[IDX_W-1:0];
                    nxt_o.dst     = reg_nib_i[IDX_W-1:0];
                    nxt_o.with_md = 1'b1;
                end
                default: begin
                    exec_o = 1'b1;
                    nxt_o  = SEL_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pfx_state_reg.sv
module pfx_state_reg
    import pfx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sel_state_t state_d,
    output sel_state_t state_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/prefix_sel_decoder.sv
module prefix_sel_decoder
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [BYTE_W-1:0] op_byte,
    output logic              o_exec,
    output logic              o_prefix,
    output logic              o_move,
    output logic              o_move_flags,
    output logic [ALT_W-1:0]  o_alt,
    output logic [IDX_W-1:0]  o_src,
    output logic [IDX_W-1:0]  o_dst,
    output logic [NIB_W-1:0]  o_op_nib,
    output logic [NIB_W-1:0]  o_reg_nib,
    output logic [IDX_W-1:0]  sel_src_q,
    output logic [IDX_W-1:0]  sel_dst_q,
    output logic [FLAG_W-1:0] status_flags
);
    kind_e            kind;
    logic [ALT_W-1:0] alt_bits;
    sel_state_t       state_d;
    sel_state_t       state_q;

    pfx_classify u_classify (
        .byte_i     (op_byte),
        .kind_o     (kind),
        .alt_bits_o (alt_bits),
        .op_nib_o   (o_op_nib),
        .reg_nib_o  (o_reg_nib)
    );

    pfx_next u_next (
        .valid_i      (op_valid),
        .kind_i       (kind),
        .alt_bits_i   (alt_bits),
        .reg_nib_i    (o_reg_nib),
        .cur_i        (state_q),
        .nxt_o        (state_d),
        .exec_o       (o_exec),
        .prefix_o     (o_prefix),
        .move_o       (o_move),
        .move_flags_o (o_move_flags),
        .alt_o        (o_alt),
        .src_o        (o_src),
        .dst_o        (o_dst)
    );

    pfx_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .state_q (state_q)
    );

    always_comb begin
        status_flags            = '0;
        status_flags[FLAG_ALT1] = state_q.alt1;
        status_flags[FLAG_ALT2] = state_q.alt2;
        status_flags[FLAG_WITH] = state_q.with_md;
        sel_src_q               = state_q.src;
        sel_dst_q               = state_q.dst;
    end

    a_r8_clear_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && o_exec) |=> (status_flags == '0 && sel_src_q == '0 && sel_dst_q == '0));

    a_r4_with_selects_both: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == K_WITH) |=> (status_flags[FLAG_WITH] && sel_src_q == sel_dst_q));

    a_r2_alt_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == K_ALT) |=>
            (({status_flags[FLAG_ALT2], status_flags[FLAG_ALT1]} & $past(alt_bits)) == $past(alt_bits)));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(status_flags) && $stable(sel_src_q) && $stable(sel_dst_q)));

    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (o_exec ^ o_prefix));

    a_r5_move_needs_with: assert property (@(posedge clk) disable iff (!rst_n)
        (o_move || o_move_flags) |-> (status_flags[FLAG_WITH] && o_exec));
endmodule

// File: tb/prefix_sel_decoder_bench.sv
module prefix_sel_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic       o_exec, o_prefix, o_move, o_move_flags;
    logic [1:0] o_alt;
    logic [3:0] o_src, o_dst, o_op_nib, o_reg_nib, sel_src_q, sel_dst_q;
    logic [15:0] status_flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prefix_sel_decoder u_prefix_sel_decoder (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .o_exec(o_exec), .o_prefix(o_prefix), .o_move(o_move), .o_move_flags(o_move_flags),
        .o_alt(o_alt), .o_src(o_src), .o_dst(o_dst), .o_op_nib(o_op_nib), .o_reg_nib(o_reg_nib),
        .sel_src_q(sel_src_q), .sel_dst_q(sel_dst_q), .status_flags(status_flags)
    );

    typedef struct {
        string      req;
        bit         valid;
        bit         exec, prefix, mv, mvf;
        bit [1:0]   alt;
        bit [3:0]   src, dst, opn, regn;
        bit [3:0]   hsrc, hdst;
        bit [15:0]  flags;
    } exp_t;

    exp_t q[$];

    // reference state, kept from the requirement text
    bit       m_a1, m_a2, m_w;
    bit [3:0] m_src, m_dst;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic exp_t held(input string req);
        exp_t e;
        e.req   = req;
        e.valid = 0;
        e.hsrc  = m_src;
        e.hdst  = m_dst;
        e.flags = 16'h0;
        e.flags[8]  = m_a1;
        e.flags[9]  = m_a2;
        e.flags[12] = m_w;
        e.exec = 0; e.prefix = 0; e.mv = 0; e.mvf = 0;
        e.alt = {m_a2, m_a1}; e.src = m_src; e.dst = m_dst; e.opn = 0; e.regn = 0;
        return e;
    endfunction

    task automatic clear_model();
        m_a1 = 0; m_a2 = 0; m_w = 0; m_src = 0; m_dst = 0;
    endtask

    task automatic send(input logic [7:0] b, input string req);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1;
        op_byte  = b;
        e = held(req);
        e.valid = 1;
        e.opn = b[7:4];
        e.regn = b[3:0];
        if (b[7:4] == 4'h3 && b[3:2] == 2'b11 && b[1:0] != 2'b00) begin
            e.prefix = 1;
            m_a1 = m_a1 | b[0];
            m_a2 = m_a2 | b[1];
        end else if (b[7:4] == 4'h2) begin
            e.prefix = 1;
            m_src = b[3:0]; m_dst = b[3:0]; m_w = 1;
        end else if (b[7:4] == 4'h1 && !m_w) begin
            e.prefix = 1;
            m_dst = b[3:0];
        end else if (b[7:4] == 4'hB && !m_w) begin
            e.prefix = 1;
            m_src = b[3:0];
        end else begin
            e.exec = 1;
            if (m_w && b[7:4] == 4'h1) begin e.mv = 1;  e.src = b[3:0]; end
            if (m_w && b[7:4] == 4'hB) begin e.mvf = 1; e.src = b[3:0]; end
            clear_model();
        end
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_byte  = 8'hFF;
            q.push_back(held(req));
        end
    endtask

    // monitor: compares mid-cycle, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(status_flags == e.flags, e.req, "status_flags", status_flags, e.flags);
                chk(sel_src_q == e.hsrc, e.req, "sel_src_q", 16'(sel_src_q), 16'(e.hsrc));
                chk(sel_dst_q == e.hdst, e.req, "sel_dst_q", 16'(sel_dst_q), 16'(e.hdst));
                chk(o_exec == e.exec, e.req, "o_exec", 16'(o_exec), 16'(e.exec));
                chk(o_prefix == e.prefix, e.req, "o_prefix", 16'(o_prefix), 16'(e.prefix));
                if (e.valid) begin
                    chk(o_move == e.mv, e.req, "o_move", 16'(o_move), 16'(e.mv));
                    chk(o_move_flags == e.mvf, e.req, "o_move_flags", 16'(o_move_flags), 16'(e.mvf));
                    chk(o_op_nib == e.opn && o_reg_nib == e.regn, e.req, "nibbles",
                        {8'h0, o_op_nib, o_reg_nib}, {8'h0, e.opn, e.regn});
                    if (e.exec) begin
                        chk(o_alt == e.alt, e.req, "o_alt", 16'(o_alt), 16'(e.alt));
                        chk(o_src == e.src, e.req, "o_src", 16'(o_src), 16'(e.src));
                        chk(o_dst == e.dst, e.req, "o_dst", 16'(o_dst), 16'(e.dst));
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1 reset state");
        send(8'h50, "R7 plain op");
        send(8'h3D, "R2 alt1");
        send(8'h5A, "R7 alt1 op");
        idle(1, "R8 cleared after issue");
        send(8'h3E, "R2 alt2");
        send(8'h3D, "R2 alt or");
        idle(1, "R11 both alt bits");
        send(8'h60, "R7 alt3 op");
        send(8'h13, "R3 to");
        send(8'hB7, "R3 from");
        send(8'h3F, "R9 alt after regs");
        send(8'hC2, "R9 issue with all");
        send(8'h3D, "R9 alt first");
        send(8'hB5, "R9 from");
        send(8'h14, "R9 to");
        send(8'h45, "R9 issue swapped");
        send(8'h24, "R4 with");
        idle(1, "R11 with bit");
        send(8'h19, "R5 move");
        idle(1, "R8 cleared after move");
        send(8'h26, "R4 with");
        send(8'h3D, "R9 alt under with");
        send(8'hB8, "R6 move flags");
        send(8'h21, "R4 with");
        send(8'h22, "R4 reselect");
        send(8'h55, "R7 issue after with");
        send(8'h15, "R3 to");
        idle(3, "R10 hold idle");
        send(8'hD0, "R10 kept over idle");
        send(8'h2F, "R4 with r15");
        send(8'h1F, "R5 move r15");
        send(8'h3C, "R7 row3 non-alt");
        send(8'h1A, "R3 to after clear");
        idle(2, "R10 final hold");
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule